// File: doc/BRIEF.md
# Serial Transmitter with Inter-Character Gap

This block turns bytes into asynchronous serial frames on a single output line. Bytes go into a small holding queue through a one-cycle write strobe. A frame engine takes them out one at a time and sends, least significant bit first: a low start bit, 5 to 8 data bits, an optional parity bit and a stop period. After every character the line is held at the idle (high) level for a programmable number of bit periods before the next start bit may begin. All timing follows an external baud tick. A bit period lasts `TPB` ticks, and `TPB` must be even so that one and a half stop bits can be represented.

The frame format comes from a line-control byte in the common 16550 layout. It is captured when each character starts, except for the break bit, which acts on the line at once. A request-to-send output either follows a software bit or is driven from the transmitter's own activity, with selectable polarity. A half-duplex direction output is asserted whenever the transmitter has work, also with selectable polarity.

The frame engine has the states IDLE, START, DATA, PARITY, STOP and GAP. Its transitions are:
- IDLE→START on a tick with the queue non-empty.
- START→DATA after one bit period.
- DATA→PARITY or DATA→STOP after the last data bit.
- PARITY→STOP after one bit period.
- STOP→GAP when the gap count is non-zero.
- STOP→START or STOP→IDLE when the gap count is zero, depending on the queue.
- GAP→START or GAP→IDLE after the last gap period, depending on the queue.

Top module: `sgtx_gap_tx`

## Requirements
- R1: Line-control bits [1:0] select the data length: codes 0, 1, 2 and 3 give 5, 6, 7 and 8 bits. Data bits follow a one-bit-period low start bit, least significant bit first.
- R2: With line-control bit 2 clear the stop period is one bit. With bit 2 set it is 1.5 bits for 5-bit data and 2 bits for any other length. The line is high during the stop period.
- R3: Line-control bit 3 adds a parity bit after the data. When bit 5 is clear, bit 4 set gives even parity (data plus parity hold an even number of ones) and bit 4 clear gives odd parity.
- R4: With bits 3 and 5 both set, the parity bit is fixed: 0 when bit 4 is set, 1 when bit 4 is clear.
- R5: While line-control bit 6 is set, the serial output is low. When it clears, the output returns to the level the engine is driving.
- R6: After each stop period the line stays high for G bit periods before the next start bit can begin. G is a gap register that resets to 0x24 and is loaded from `gap_val` when `gap_we` is high. With G = 0, queued characters follow each other with no idle time.
- R7: The queue holds `DEPTH` bytes (default 4) and sends them in write order. `thr_room` is high whenever fewer than `DEPTH` bytes are queued. A write while the queue is full is dropped.
- R8: With `rts_auto` high, request-to-send is active from the cycle after a byte is accepted until the final gap period ends with the queue empty. With `rts_auto` low, it is active exactly when `rts_sw` is high.
- R9: `rts_o` equals `rts_act_high` when request-to-send is active and its inverse otherwise.
- R10: `dir_o` equals `dir_tx_high` while the queue is non-empty or the engine is outside IDLE, and its inverse otherwise.
- R11: After reset the line is high, `thr_room` is high, the engine is in IDLE, and both `rts_o` and `dir_o` are at their inactive levels.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| baud_tick | input | 1 | One-cycle pulse; TPB pulses make one bit period |
| wr_en | input | 1 | Write strobe into the holding queue |
| wr_byte | input | 8 | Byte to queue |
| line_cfg | input | 8 | Line-control byte (length, stop, parity, break) |
| gap_we | input | 1 | Load strobe for the gap register |
| gap_val | input | 8 | New gap length in bit periods |
| rts_auto | input | 1 | Drive request-to-send from transmitter activity |
| rts_sw | input | 1 | Software request-to-send when not automatic |
| rts_act_high | input | 1 | Request-to-send active level is high |
| dir_tx_high | input | 1 | Direction output is high while transmitting |
| txd | output | 1 | Serial output line |
| thr_room | output | 1 | Queue can take another byte |
| rts_o | output | 1 | Request-to-send pin |
| dir_o | output | 1 | Half-duplex direction pin |

## Verification
The embedded properties check on every cycle that:
- the queue count never exceeds its depth and is left unchanged by a write while full;
- the engine never pops an empty queue;
- the data-bit index stays inside the captured length;
- the engine leaves GAP for START only once the gap count has run out;
- request-to-send and direction sit at their active levels whenever work is pending.

Only the bench scenarios can show that the bit sequences are right:
- data order and parity values;
- the 1.5-stop case;
- the exact spacing between consecutive start edges;
- the moment the pins release after the last gap;
- the loss of a byte written into a full queue.

// File: rtl/sgtx_pkg.sv
package sgtx_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PARITY,
        ST_STOP,
        ST_GAP
    } sgtx_state_e;

    // Per-character frame format, captured at character start
    typedef struct packed {
        logic [1:0] len_code;
        logic       long_stop;
        logic       par_on;
        logic       par_even;
        logic       par_stick;
    } sgtx_fmt_t;

    function automatic sgtx_fmt_t decode_fmt(input logic [7:0] c);
        sgtx_fmt_t f;
        f.len_code  = c[1:0];
        f.long_stop = c[2];
        f.par_on    = c[3];
        f.par_even  = c[4];
        f.par_stick = c[5];
        return f;
    endfunction

    function automatic logic parity_bit(input sgtx_fmt_t f, input logic [7:0] d);
        logic [7:0] m;
        m = d & (8'hFF >> (2'd3 - f.len_code));
        if (f.par_stick) begin
            return ~f.par_even;
        end
        return f.par_even ? ^m : ~^m;
    endfunction

endpackage

// File: rtl/sgtx_fifo.sv
module sgtx_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr,
    input  logic [W-1:0] wdata,
    input  logic         rd,
    output logic [W-1:0] rdata,
    output logic         empty,
    output logic         full
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);
    localparam logic [CW-1:0] CMAX = CW'(DEPTH);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wptr, rptr;
    logic [CW-1:0] cnt;
    logic          do_wr, do_rd;

    assign full  = (cnt == CMAX);
    assign empty = (cnt == '0);
    assign do_wr = wr && !full;
    assign do_rd = rd && !empty;
    assign rdata = mem[rptr];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wptr <= '0;
            rptr <= '0;
            cnt  <= '0;
        end else begin
            if (do_wr) begin
                wptr <= (wptr == LAST) ? '0 : wptr + 1'b1;
            end
            if (do_rd) begin
                rptr <= (rptr == LAST) ? '0 : rptr + 1'b1;
            end
            if (do_wr && !do_rd) begin
                cnt <= cnt + 1'b1;
            end else if (do_rd && !do_wr) begin
                cnt <= cnt - 1'b1;
            end
        end
    end

    generate
        for (genvar i = 0; i < DEPTH; i++) begin : g_slot
            always_ff @(posedge clk) begin
                if (do_wr && wptr == AW'(i)) begin
                    mem[i] <= wdata;
                end
            end
        end
    endgenerate

    // R7
    fifo_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CMAX);

    // R7
    full_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(cnt) == CMAX && !$past(rd)) |-> (cnt == CMAX));

    // R7
    no_underrun_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd |-> !empty);

endmodule

// File: rtl/sgtx_frame_fsm.sv
module sgtx_frame_fsm
    import sgtx_pkg::*;
#(
    parameter int         TPB     = 2,
    parameter logic [7:0] GAP_RST = 8'h24
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        tick,
    input  logic [7:0]  cfg,
    input  logic        gap_we,
    input  logic [7:0]  gap_val,
    input  logic        fifo_empty,
    input  logic [7:0]  fifo_data,
    output logic        fifo_pop,
    output logic        txd,
    output logic        active
);
    localparam int TCW = $clog2(2 * TPB);
    localparam logic [TCW:0] L_ONE     = (TCW + 1)'(TPB);
    localparam logic [TCW:0] L_ONEHALF = (TCW + 1)'(TPB + TPB / 2);
    localparam logic [TCW:0] L_TWO     = (TCW + 1)'(2 * TPB);

    sgtx_state_e    state_q, state_d;
    sgtx_fmt_t      fmt_q;
    logic [TCW-1:0] tcnt;
    logic [TCW:0]   lim;
    logic [2:0]     bidx;
    logic [7:0]     gcnt, gap_q, shreg;
    logic           par_q;
    logic           bit_end, last_data, gap_last, pop;

    // Length of the current bit slot in ticks
    always_comb begin
        if (state_q == ST_STOP && fmt_q.long_stop) begin
            lim = (fmt_q.len_code == 2'd0) ? L_ONEHALF : L_TWO;
        end else begin
            lim = L_ONE;
        end
    end

    assign bit_end   = tick && ({1'b0, tcnt} == lim - 1'b1);
    assign last_data = (bidx == ({1'b0, fmt_q.len_code} + 3'd4));
    assign gap_last  = (({1'b0, gcnt} + 9'd1) >= {1'b0, gap_q});

    // Next state
    always_comb begin
        state_d = state_q;
        pop     = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (tick && !fifo_empty) begin
                    state_d = ST_START;
                    pop     = 1'b1;
                end
            end
            ST_START: begin
                if (bit_end) state_d = ST_DATA;
            end
            ST_DATA: begin
                if (bit_end && last_data) begin
                    state_d = fmt_q.par_on ? ST_PARITY : ST_STOP;
                end
            end
            ST_PARITY: begin
                if (bit_end) state_d = ST_STOP;
            end
            ST_STOP: begin
                if (bit_end) begin
                    if (gap_q != 8'd0) begin
                        state_d = ST_GAP;
                    end else if (!fifo_empty) begin
                        state_d = ST_START;
                        pop     = 1'b1;
                    end else begin
                        state_d = ST_IDLE;
                    end
                end
            end
            ST_GAP: begin
                if (bit_end && gap_last) begin
                    if (!fifo_empty) begin
                        state_d = ST_START;
                        pop     = 1'b1;
                    end else begin
                        state_d = ST_IDLE;
                    end
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State register and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            fmt_q   <= '0;
            tcnt    <= '0;
            bidx    <= '0;
            gcnt    <= '0;
            shreg   <= '0;
            par_q   <= 1'b0;
            gap_q   <= GAP_RST;
        end else begin
            state_q <= state_d;
            if (gap_we) begin
                gap_q <= gap_val;
            end
            if (pop) begin
                shreg <= fifo_data;
                fmt_q <= decode_fmt(cfg);
                par_q <= parity_bit(decode_fmt(cfg), fifo_data);
            end
            if (tick && state_q != ST_IDLE) begin
                tcnt <= bit_end ? '0 : tcnt + 1'b1;
            end
            if (bit_end) begin
                unique case (state_q)
                    ST_START: bidx <= '0;
                    ST_DATA: begin
                        if (!last_data) begin
                            bidx  <= bidx + 1'b1;
                            shreg <= {1'b0, shreg[7:1]};
                        end
                    end
                    ST_STOP: gcnt <= '0;
                    ST_GAP: begin
                        if (!gap_last) gcnt <= gcnt + 1'b1;
                    end
                    default: ;
                endcase
            end
        end
    end

    // Outputs
    always_comb begin
        fifo_pop = pop;
        active   = (state_q != ST_IDLE);
        unique case (state_q)
            ST_START:  txd = 1'b0;
            ST_DATA:   txd = shreg[0];
            ST_PARITY: txd = par_q;
            default:   txd = 1'b1;
        endcase
        if (cfg[6]) begin
            txd = 1'b0;
        end
    end

    // R1
    bit_idx_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DATA) |-> (bidx <= ({1'b0, fmt_q.len_code} + 3'd4)));

    // R6
    gap_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_START && $past(state_q) == ST_GAP)
            |-> (({1'b0, $past(gcnt)} + 9'd1) >= {1'b0, $past(gap_q)}));

endmodule

// File: rtl/sgtx_line_ctl.sv
module sgtx_line_ctl (
    input  logic busy,
    input  logic rts_auto,
    input  logic rts_sw,
    input  logic rts_act_high,
    input  logic dir_tx_high,
    output logic rts_o,
    output logic dir_o
);
    logic rts_on;

    always_comb begin
        rts_on = rts_auto ? busy : rts_sw;
        rts_o  = rts_act_high ? rts_on : ~rts_on;
        dir_o  = dir_tx_high ? busy : ~busy;
    end

endmodule

// File: rtl/sgtx_gap_tx.sv
module sgtx_gap_tx #(
    parameter int         TPB     = 2,
    parameter int         DEPTH   = 4,
    parameter logic [7:0] GAP_RST = 8'h24
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       baud_tick,
    input  logic       wr_en,
    input  logic [7:0] wr_byte,
    input  logic [7:0] line_cfg,
    input  logic       gap_we,
    input  logic [7:0] gap_val,
    input  logic       rts_auto,
    input  logic       rts_sw,
    input  logic       rts_act_high,
    input  logic       dir_tx_high,
    output logic       txd,
    output logic       thr_room,
    output logic       rts_o,
    output logic       dir_o
);
    logic [7:0] q_data;
    logic       q_empty, q_full, q_pop, eng_active, busy;

    sgtx_fifo #(.W(8), .DEPTH(DEPTH)) u_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .wr    (wr_en),
        .wdata (wr_byte),
        .rd    (q_pop),
        .rdata (q_data),
        .empty (q_empty),
        .full  (q_full)
    );

    sgtx_frame_fsm #(.TPB(TPB), .GAP_RST(GAP_RST)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (baud_tick),
        .cfg        (line_cfg),
        .gap_we     (gap_we),
        .gap_val    (gap_val),
        .fifo_empty (q_empty),
        .fifo_data  (q_data),
        .fifo_pop   (q_pop),
        .txd        (txd),
        .active     (eng_active)
    );

    assign busy     = eng_active || !q_empty;
    assign thr_room = !q_full;

    sgtx_line_ctl u_line (
        .busy         (busy),
        .rts_auto     (rts_auto),
        .rts_sw       (rts_sw),
        .rts_act_high (rts_act_high),
        .dir_tx_high  (dir_tx_high),
        .rts_o        (rts_o),
        .dir_o        (dir_o)
    );

    // R8
    auto_rts_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rts_auto && eng_active) |-> (rts_o == rts_act_high));

    // R10
    dir_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!q_empty) |-> (dir_o == dir_tx_high));

endmodule

// File: tb/sgtx_gap_tx_test.sv
`timescale 1ns/1ps
module sgtx_gap_tx_test;
    localparam int DEPTH = 4;

    logic       clk = 1'b0, rst_n = 1'b0, baud_tick = 1'b0;
    logic       wr_en = 1'b0, gap_we = 1'b0;
    logic [7:0] wr_byte = 8'h00, line_cfg = 8'h03, gap_val = 8'h00;
    logic       rts_auto = 1'b1, rts_sw = 1'b0, rts_act_high = 1'b0, dir_tx_high = 1'b1;
    logic       txd, thr_room, rts_o, dir_o;

    int n_tests = 0, n_fail = 0;
    bit tick_en = 1'b0;
    int tick_ph = 0;
    logic exp_v [0:1023];
    int   exp_h;

    always #2.5 clk = ~clk;

    sgtx_gap_tx #(.TPB(2), .DEPTH(DEPTH), .GAP_RST(8'h24)) uut (
        .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .wr_en(wr_en),
        .wr_byte(wr_byte), .line_cfg(line_cfg), .gap_we(gap_we), .gap_val(gap_val),
        .rts_auto(rts_auto), .rts_sw(rts_sw), .rts_act_high(rts_act_high),
        .dir_tx_high(dir_tx_high), .txd(txd), .thr_room(thr_room),
        .rts_o(rts_o), .dir_o(dir_o)
    );

    // one tick every 4 cycles; with TPB=2 a half bit lasts 4 cycles
    always @(negedge clk) begin
        if (tick_en) begin
            tick_ph   = (tick_ph + 1) % 4;
            baud_tick <= (tick_ph == 0);
        end else begin
            baud_tick <= 1'b0;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // expected line levels in half-bit units, start bit to end of gap
    task automatic build(input logic [7:0] cfg, input logic [7:0] d, input int gap);
        int h, dl, st;
        logic [7:0] m;
        logic p;
        h  = 0;
        dl = int'(cfg[1:0]) + 5;
        m  = d & (8'hFF >> (8 - dl));
        for (int k = 0; k < 2; k++) begin exp_v[h] = 1'b0; h++; end
        for (int i = 0; i < dl; i++) begin
            for (int k = 0; k < 2; k++) begin exp_v[h] = d[i]; h++; end
        end
        if (cfg[3]) begin
            p = cfg[5] ? !cfg[4] : (cfg[4] ? ^m : ~^m);
            for (int k = 0; k < 2; k++) begin exp_v[h] = p; h++; end
        end
        st = !cfg[2] ? 2 : ((dl == 5) ? 3 : 4);
        for (int k = 0; k < st + 2 * gap; k++) begin exp_v[h] = 1'b1; h++; end
        exp_h = h;
    endtask

    task automatic wait_fall(output bit ok);
        ok = 1'b0;
        for (int i = 0; i < 4000; i++) begin
            @(negedge clk);
            if (txd === 1'b0) begin ok = 1'b1; return; end
        end
    endtask

    // called at the negedge where the start edge was seen; returns at 4H-2
    task automatic check_frame(input string req);
        for (int h = 0; h < exp_h; h++) begin
            repeat ((h == 0) ? 2 : 4) @(negedge clk);
            chk(req, txd, exp_v[h]);
        end
    endtask

    task automatic put_byte(input logic [7:0] d);
        @(negedge clk); wr_en = 1'b1; wr_byte = d;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic run_pair(input logic [7:0] cfg, input logic [7:0] d0, input logic [7:0] d1,
                            input int gap, input bit load_gap, input string req);
        bit ok;
        tick_en = 1'b0;
        @(negedge clk);
        line_cfg = cfg;
        if (load_gap) begin
            gap_we = 1'b1; gap_val = 8'(gap);
            @(negedge clk); gap_we = 1'b0;
        end
        put_byte(d0);
        put_byte(d1);
        tick_en = 1'b1;
        wait_fall(ok);
        chk({req, " first start seen"}, 32'(ok), 32'd1);
        build(cfg, d0, gap);
        check_frame({req, " frame0"});
        chk("R10 dir active mid stream", dir_o, dir_tx_high);
        repeat (2) @(negedge clk);
        chk("R6 next start exactly after gap", txd, 1'b0);
        build(cfg, d1, gap);
        check_frame({req, " frame1"});
        chk("R8 auto rts active in last gap", rts_o, rts_act_high);
        repeat (3) @(negedge clk);
        chk("R8 auto rts released after gap", rts_o, !rts_act_high);
        chk("R10 dir released after gap", dir_o, !dir_tx_high);
        chk("R6 line idle after gap", txd, 1'b1);
    endtask

    initial begin
        #(5.0 * 150000);
        n_fail++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        bit ok;
        int lows;
        logic [7:0] cfg, d0, d1;
        logic [7:0] qd [0:4];
        void'($urandom(32'd20240611));
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11 reset state
        chk("R11 txd idle high", txd, 1'b1);
        chk("R11 thr_room", thr_room, 1'b1);
        chk("R11 rts inactive", rts_o, 1'b1);
        chk("R11 dir inactive", dir_o, 1'b0);

        // R6 reset gap value 0x24, 8 data bits, no parity
        run_pair(8'h03, 8'hA5, 8'h3C, 36, 1'b0, "R6 R1 default gap");
        // R2 1.5 stop with 5 bits, gap 0
        run_pair(8'h04, 8'h15, 8'h0A, 0, 1'b1, "R2 R1 five bits long stop");
        // R3 even parity, 6 bits, 2 stop
        rts_act_high = 1'b1;
        run_pair(8'h1D, 8'h2D, 8'h13, 1, 1'b1, "R3 R2 R9 even parity");
        // R3 odd parity, 7 bits
        dir_tx_high = 1'b0;
        run_pair(8'h0A, 8'h55, 8'h7F, 2, 1'b1, "R3 R10 odd parity");
        // R4 sticky parity
        run_pair(8'h3B, 8'hFF, 8'h01, 0, 1'b1, "R4 sticky even sends 0");
        run_pair(8'h2B, 8'h00, 8'h80, 1, 1'b1, "R4 sticky odd sends 1");
        dir_tx_high = 1'b1;
        rts_act_high = 1'b0;

        // random formats
        for (int it = 0; it < 16; it++) begin
            cfg = 8'($urandom) & 8'h3F;
            d0  = 8'($urandom);
            d1  = 8'($urandom);
            rts_act_high = 1'($urandom);
            dir_tx_high  = 1'($urandom);
            run_pair(cfg, d0, d1, int'($urandom % 4), 1'b1, "R1 R2 R3 R4 random");
        end
        rts_act_high = 1'b0;
        dir_tx_high  = 1'b1;

        // R8 R9 manual request-to-send
        rts_auto = 1'b0;
        rts_sw = 1'b1; rts_act_high = 1'b1; @(negedge clk);
        chk("R8 R9 manual rts on, active high", rts_o, 1'b1);
        rts_act_high = 1'b0; @(negedge clk);
        chk("R8 R9 manual rts on, active low", rts_o, 1'b0);
        rts_sw = 1'b0; @(negedge clk);
        chk("R8 manual rts off", rts_o, 1'b1);
        rts_auto = 1'b1;

        // R5 break
        line_cfg = 8'h43; @(negedge clk);
        chk("R5 break forces low", txd, 1'b0);
        repeat (10) @(negedge clk);
        chk("R5 break held", txd, 1'b0);
        line_cfg = 8'h03; @(negedge clk);
        chk("R5 break released", txd, 1'b1);

        // R7 overflow: fill with ticks stopped
        tick_en = 1'b0;
        @(negedge clk); gap_we = 1'b1; gap_val = 8'd0;
        @(negedge clk); gap_we = 1'b0;
        for (int i = 0; i < 5; i++) begin
            qd[i] = 8'(8'h11 * (i + 1));
            put_byte(qd[i]);
            if (i == DEPTH - 2) chk("R7 room with one slot left", thr_room, 1'b1);
            if (i >= DEPTH - 1) chk("R7 full clears room", thr_room, 1'b0);
        end
        tick_en = 1'b1;
        for (int f = 0; f < DEPTH; f++) begin
            if (f == 0) begin
                wait_fall(ok);
                chk("R7 queue drains", 32'(ok), 32'd1);
            end else begin
                repeat (2) @(negedge clk);
                chk("R7 back-to-back start", txd, 1'b0);
            end
            build(8'h03, qd[f], 0);
            check_frame("R7 order");
        end
        repeat (2) @(negedge clk);
        lows = 0;
        for (int i = 0; i < 200; i++) begin
            @(negedge clk);
            if (txd === 1'b0) lows++;
        end
        chk("R7 dropped byte never sent", 32'(lows), 32'd0);
        chk("R7 room after drain", thr_room, 1'b1);

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule